// File: doc/BRIEF.md
# Reference Retiming Path Selector

This block brings an asynchronous reference signal into the domain of a fast variable clock without letting the capture flop see a reference edge that lands right next to its sampling edge. The reference is captured twice: once on the rising edge of the variable clock, and once on the falling edge. A 2:1 multiplexer picks one of the two captures. A final register on the rising edge re-times the chosen capture into the retimed reference. A one-cycle tick marks each rising edge of the retimed reference, and the low-speed logic of a fractional-N phase-domain loop uses this tick as its clock enable.

The multiplexer select comes from the thermometer word of a time-to-digital converter, which measures where the reference edge sits inside the variable clock period. The block scans that word for the lowest stage whose bit differs from stage 0. A low-to-high transition that lies within the first quarter of the period means the reference edge is too near the rising edge, so the falling-edge capture is used. Any other transition selects the rising-edge capture. A word with no transition keeps the select as it is.

The quarter-period threshold is the period length in stages, given as an input, shifted right by two. The select is re-evaluated once per reference cycle, on the edge where the retimed reference rises, and it is held between those edges.

Top module: `rtsel_retimer`

## Requirements
- R1: With path select 0 (rising-edge capture), a reference level that changes just after a rising edge of the variable clock appears on `ref_retimed` after the second rising edge that follows the change.
- R2: With path select 1 (falling-edge capture), a reference level that changes just after a rising edge appears on `ref_retimed` after the very next rising edge, having been caught on the falling edge in between.
- R3: `ref_tick` is high for exactly one cycle, in the cycle in which `ref_retimed` has just gone from 0 to 1, and stays low while the reference stays high.
- R4: The transition stage k is the lowest index whose `tdc_code` bit differs from bit 0, and the transition is rising when bit 0 is 0. If the transition is rising and k < `period_len` >> 2, `path_sel` becomes 1 at the edge where `ref_retimed` rises.
- R5: If all `tdc_code` bits are equal, `path_sel` keeps its value. `path_sel` changes at no edge other than one where `ref_retimed` rises, whatever `tdc_code` does in between.
- R6: A falling transition at any stage, or a rising transition with k >= `period_len` >> 2, makes `path_sel` 0 at the edge where `ref_retimed` rises.
- R7: While `rst_n` is low, and until the reset has been released on two rising edges, `ref_retimed`, `ref_tick` and `path_sel` are 0.
- R8: The threshold follows `period_len` as it stands on each update edge, so the same stage k can select either path depending on the period that is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_v | input | 1 | Variable (oscillator-derived) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Asynchronous reference level |
| tdc_code | input | 128 | Thermometer word from the time-to-digital converter |
| period_len | input | 8 | Variable clock period measured in delay stages |
| ref_retimed | output | 1 | Reference re-timed to the rising edge of clk_v |
| ref_tick | output | 1 | One-cycle enable on each rising edge of ref_retimed |
| path_sel | output | 1 | Current capture path: 0 rising edge, 1 falling edge |

## Verification
The reference is raised a short time after a rising edge, under each path select. The retimed output then arrives one cycle earlier on the falling-edge path, and this difference shows which capture is actually in use. The words applied cover the following cases:
- words with no transition, which must leave the select unchanged;
- rising transitions well below, one stage below, and exactly at the quarter-period threshold, which separate a strict comparison from an inclusive one;
- a falling transition at a low stage, which must not be mistaken for a rising one;
- one stage tested under two different period lengths, which shows that the threshold follows the input.

While the reference is high, the bench applies a word that points the other way, to show that the select is only updated at the retiming edge.

// File: rtl/rtsel_pkg.sv
package rtsel_pkg;
  // Capture path encoding driven on path_sel
  typedef enum logic {
    PATH_RISE = 1'b0,
    PATH_FALL = 1'b1
  } path_e;

  // Summary of one scan over the thermometer word
  typedef struct packed {
    logic found;   // some stage differs from stage 0
    logic rising;  // stage 0 is low, so the step goes 0 -> 1
  } scan_t;
endpackage

// File: rtl/rtsel_rst_sync.sv
module rtsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtsel_dual_sampler.sv
module rtsel_dual_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_rise,
  output logic q_fall
);
  logic rise_d;
  logic fall_d;

  always_comb begin
    rise_d = d_in;
    fall_d = d_in;
  end

  // Capture on the rising edge of the variable clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_rise <= 1'b0;
    else        q_rise <= rise_d;
  end

  // Capture on the falling edge (inverted clock) of the variable clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= 1'b0;
    else        q_fall <= fall_d;
  end
endmodule

// File: rtl/rtsel_edge_scan.sv
module rtsel_edge_scan
  import rtsel_pkg::*;
#(
  parameter int STAGES = 128,
  localparam int POS_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] code,
  output scan_t             info,
  output logic [POS_W-1:0]  pos
);
  logic [STAGES-1:0] differs;

  // One difference flag per stage against the reference stage 0
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_diff
      if (g == 0) begin : g_ref
        assign differs[g] = 1'b0;
      end else begin : g_cmp
        assign differs[g] = code[g] ^ code[0];
      end
    end
  endgenerate

  // Priority scan: the lowest differing stage wins
  always_comb begin
    info.found  = 1'b0;
    info.rising = ~code[0];
    pos         = '0;
    for (int i = STAGES - 1; i >= 1; i--) begin
      if (differs[i]) begin
        info.found = 1'b1;
        pos        = POS_W'(i);
      end
    end
  end
endmodule

// File: rtl/rtsel_path_decide.sv
module rtsel_path_decide
  import rtsel_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int PER_W = 8,
  localparam int CMP_W = (POS_W > PER_W) ? POS_W : PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  scan_t            info,
  input  logic [POS_W-1:0] pos,
  input  logic [PER_W-1:0] period_len,
  output logic             pick_fall,
  output path_e            sel
);
  logic [CMP_W-1:0] pos_ext;
  logic [CMP_W-1:0] quarter;
  path_e            sel_d;

  always_comb begin
    pos_ext   = CMP_W'(pos);
    quarter   = CMP_W'(period_len >> 2);
    // A rising step early in the period means the reference is near the rising edge
    pick_fall = info.found & info.rising & (pos_ext < quarter);
    sel_d     = sel;
    if (update && info.found) begin
      sel_d = pick_fall ? PATH_FALL : PATH_RISE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= PATH_RISE;
    else        sel <= sel_d;
  end
endmodule

// File: rtl/rtsel_retimer.sv
module rtsel_retimer
  import rtsel_pkg::*;
#(
  parameter int STAGES = 128,
  parameter int PER_W  = 8,
  localparam int POS_W = $clog2(STAGES)
) (
  input  logic              clk_v,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [STAGES-1:0] tdc_code,
  input  logic [PER_W-1:0]  period_len,
  output logic              ref_retimed,
  output logic              ref_tick,
  output logic              path_sel
);
  logic             srst_n;
  logic             samp_a;
  logic             samp_b;
  logic             mux_out;
  logic             rt_q;
  logic             rt_d;
  logic             tick_q;
  logic             tick_d;
  logic             scan_found;
  logic             pick_b;
  scan_t            scan_info;
  logic [POS_W-1:0] scan_pos;
  path_e            sel;

  rtsel_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_v),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rtsel_dual_sampler u_samp (
    .clk    (clk_v),
    .rst_n  (srst_n),
    .d_in   (ref_in),
    .q_rise (samp_a),
    .q_fall (samp_b)
  );

  rtsel_edge_scan #(.STAGES(STAGES)) u_scan (
    .code (tdc_code),
    .info (scan_info),
    .pos  (scan_pos)
  );

  assign scan_found = scan_info.found;

  // Retiming edge of the chosen capture
  always_comb begin
    mux_out = (sel == PATH_FALL) ? samp_b : samp_a;
    rt_d    = mux_out;
    tick_d  = mux_out & ~rt_q;
  end

  rtsel_path_decide #(.POS_W(POS_W), .PER_W(PER_W)) u_dec (
    .clk        (clk_v),
    .rst_n      (srst_n),
    .update     (tick_d),
    .info       (scan_info),
    .pos        (scan_pos),
    .period_len (period_len),
    .pick_fall  (pick_b),
    .sel        (sel)
  );

  always_ff @(posedge clk_v or negedge srst_n) begin
    if (!srst_n) begin
      rt_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      rt_q   <= rt_d;
      tick_q <= tick_d;
    end
  end

  assign ref_retimed = rt_q;
  assign ref_tick    = tick_q;
  assign path_sel    = sel;
endmodule

// File: rtl/rtsel_retimer_chk.sv
module rtsel_retimer_chk (
  input logic clk_v,
  input logic rst_n,
  input logic ref_retimed,
  input logic ref_tick,
  input logic path_sel,
  input logic samp_a,
  input logic samp_b,
  input logic scan_found,
  input logic pick_b
);
  AST_RISE_PATH_FEEDS: assert property (@(posedge clk_v) disable iff (!rst_n)
    !$past(path_sel) |-> ref_retimed == $past(samp_a)); // R1

  AST_FALL_PATH_FEEDS: assert property (@(posedge clk_v) disable iff (!rst_n)
    $past(path_sel) |-> ref_retimed == $past(samp_b)); // R2

  AST_TICK_MARKS_RISE: assert property (@(posedge clk_v) disable iff (!rst_n)
    ref_tick == (ref_retimed && !$past(ref_retimed))); // R3

  AST_TICK_SINGLE: assert property (@(posedge clk_v) disable iff (!rst_n)
    ref_tick |=> !ref_tick); // R3

  AST_SEL_ONLY_AT_RISE: assert property (@(posedge clk_v) disable iff (!rst_n)
    (path_sel != $past(path_sel)) |-> (ref_retimed && !$past(ref_retimed))); // R5

  AST_SEL_FOLLOWS_SCAN: assert property (@(posedge clk_v) disable iff (!rst_n)
    (ref_tick && $past(scan_found)) |-> path_sel == $past(pick_b)); // R4
endmodule

bind rtsel_retimer rtsel_retimer_chk u_chk (
  .clk_v       (clk_v),
  .rst_n       (rst_n),
  .ref_retimed (ref_retimed),
  .ref_tick    (ref_tick),
  .path_sel    (path_sel),
  .samp_a      (samp_a),
  .samp_b      (samp_b),
  .scan_found  (scan_found),
  .pick_b      (pick_b)
);

// File: tb/rtsel_retimer_tb.sv
module rtsel_retimer_tb;
  localparam int N = 128;

  logic         clk_v;
  logic         rst_n;
  logic         ref_in;
  logic [N-1:0] tdc_code;
  logic [7:0]   period_len;
  logic         ref_retimed;
  logic         ref_tick;
  logic         path_sel;

  int n_tests;
  int n_fail;

  rtsel_retimer u_dut (
    .clk_v       (clk_v),
    .rst_n       (rst_n),
    .ref_in      (ref_in),
    .tdc_code    (tdc_code),
    .period_len  (period_len),
    .ref_retimed (ref_retimed),
    .ref_tick    (ref_tick),
    .path_sel    (path_sel)
  );

  initial clk_v = 1'b0;
  always #10 clk_v = ~clk_v;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind 0: all zero, 1: all one, 2: rising step at k, 3: falling step at k
  function automatic logic [N-1:0] mk(input int kind, input int k);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: c[i] = 1'b0;
        1: c[i] = 1'b1;
        2: c[i] = (i >= k);
        default: c[i] = (i < k);
      endcase
    end
    return c;
  endfunction

  // One reference cycle: raise ref just after a rising edge, check retiming and select
  task automatic ref_cycle(input logic [N-1:0] code, input int per, input bit cur,
                           input bit exp, input string req);
    @(posedge clk_v); #2;
    tdc_code   = code;
    period_len = 8'(per);
    ref_in     = 1'b1;
    @(posedge clk_v); #5;
    if (!cur) begin
      check(ref_retimed == 1'b0, "R1 rise path still low one edge after", ref_retimed, 0);
      @(posedge clk_v); #5;
    end
    check(ref_retimed == 1'b1, cur ? "R2 fall path latency" : "R1 rise path latency",
          ref_retimed, 1);
    check(ref_tick == 1'b1, "R3 tick on retimed rise", ref_tick, 1);
    check(path_sel == exp, req, path_sel, exp);
    // Code pointing the other way while ref stays high must not move the select
    tdc_code = exp ? mk(3, 1) : mk(2, 1);
    @(posedge clk_v); #5;
    check(ref_tick == 1'b0, "R3 tick lasts one cycle", ref_tick, 0);
    repeat (3) @(posedge clk_v);
    #5;
    check(ref_tick == 1'b0 && ref_retimed == 1'b1, "R3 no tick while ref high",
          ref_tick, 0);
    check(path_sel == exp, "R5 select held between reference edges", path_sel, exp);
    ref_in = 1'b0;
    repeat (4) @(posedge clk_v);
    #5;
    check(ref_retimed == 1'b0, "R1 retimed returns low", ref_retimed, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_in = 1'b0; tdc_code = '0; period_len = 8'd40;
    repeat (3) @(posedge clk_v);
    #5;
    check(ref_retimed == 0 && ref_tick == 0 && path_sel == 0, "R7 reset outputs",
          {ref_retimed, ref_tick, path_sel}, 0);
    @(posedge clk_v); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk_v);
    #5;
    check(path_sel == 0 && ref_retimed == 0, "R7 after release", path_sel, 0);
  endtask

  task automatic t_main();
    ref_cycle(mk(0, 0),  40, 1'b0, 1'b0, "R5 no transition keeps rise path");
    ref_cycle(mk(2, 5),  40, 1'b0, 1'b1, "R4 early rising step picks fall path");
    ref_cycle(mk(1, 0),  40, 1'b1, 1'b1, "R5 all ones keeps fall path");
    ref_cycle(mk(2, 12), 40, 1'b1, 1'b0, "R6 late rising step picks rise path");
    ref_cycle(mk(2, 9),  40, 1'b0, 1'b1, "R4 step one below quarter");
    ref_cycle(mk(2, 10), 40, 1'b1, 1'b0, "R6 step equal to quarter");
    ref_cycle(mk(2, 5),  40, 1'b0, 1'b1, "R4 early rising step again");
    ref_cycle(mk(3, 3),  40, 1'b1, 1'b0, "R6 falling step picks rise path");
    ref_cycle(mk(2, 20), 100, 1'b0, 1'b1, "R8 long period puts k=20 below quarter");
    ref_cycle(mk(2, 20), 40, 1'b1, 1'b0, "R8 short period puts k=20 above quarter");
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    fork
      begin
        t_reset();
        t_main();
      end
      begin
        repeat (5000) @(posedge clk_v);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule